// File: doc/BRIEF.md
# Column Memory SPI Interface

This block is the serial front end of a column-driver chip. An SPI master clocks in a frame made of a small soft-command field and one ON/OFF bit for every column. The block holds the committed bits in a column memory and drives one enable output per column. Each enable output selects the high or the low reference of that column's voltage DAC.

Every SPI frame also serves as the pixel hard-reset phase. While chip select is low, all column enables are held at OFF. When chip select rises, a complete frame is committed, and the columns show the new values from that same clock edge onward. A frame of the wrong length is dropped, and the columns then return to the values they held before.

The data-out line shifts back the contents committed before the current frame, so the master can check what it last wrote. All SPI inputs pass through synchronisers and are sampled in the system clock domain.

Top module: `colmem_spi_top`

## Requirements
- R1: While reset is asserted, and after it is released, `col_on_o` is all zero, `cmd_o` is zero and `spi_miso_o` is low.
- R2: Data is taken MSB first on rising `spi_sclk_i`. The first 8 bits of a frame form the command, with the first bit landing in `cmd_o[7]`. The next 64 bits are the column word, with the first of them landing in `col_on_o[63]` and the last in `col_on_o[0]`.
- R3: Within a few system clocks after `spi_csn_i` falls, every bit of `col_on_o` is 0 and stays 0 until chip select rises.
- R4: When chip select rises after exactly 72 rising `spi_sclk_i` edges, `cmd_o` and the column memory take the received values. `col_on_o` shows the new word, with no cycle that shows the old word.
- R5: When chip select rises after any other count of rising clock edges (0, fewer than 72, or more than 72), the command and the column memory keep their old values, and `col_on_o` returns to the old word.
- R6: During a frame, `spi_miso_o` presents the word {command, column memory} as it stood before the frame, MSB first. The first bit is valid before the first rising clock edge, and the line advances on each falling edge. While chip select is high, `spi_miso_o` is low.
- R7: `cmd_o` changes only on the commit at the rise of chip select. It holds its value for the whole time chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_sclk_i | input | 1 | SPI serial clock |
| spi_csn_i | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | SPI data in |
| spi_miso_o | output | 1 | SPI data out (readback) |
| col_on_o | output | 64 | Per-column ON/OFF level select |
| cmd_o | output | 8 | Committed soft-command field |

## Verification
The bench builds the block with its defaults: 64 columns split into two groups of 32, an 8-bit command and two synchroniser stages. This places the commit check on a 72-bit frame, and the vectors set bits on both sides of the bit 31/32 boundary between the groups. Frames of 0, 71 and 73 bits drive the edge counter below, just short of, and past its exact-length value, including the saturating slot. Every frame compares the readback bits against the word committed before it.

// File: rtl/colmem_pkg.sv
package colmem_pkg;
  localparam int unsigned COL_W_DEF  = 64;
  localparam int unsigned CMD_W_DEF  = 8;
  localparam int unsigned GROUPS_DEF = 2;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              d_i,
  output colmem_pkg::edge_t e_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign e_o.level = sync_q[STAGES-1];
  assign e_o.rise  = sync_q[STAGES-1] & ~prev_q;
  assign e_o.fall  = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
  parameter int unsigned CMD_W   = 8,
  parameter int unsigned COL_W   = 64,
  localparam int unsigned FRAME_W = CMD_W + COL_W,
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  colmem_pkg::edge_t  sclk_e_i,
  input  colmem_pkg::edge_t  csn_e_i,
  input  logic               mosi_i,
  input  logic [FRAME_W-1:0] rb_word_i,
  output logic [FRAME_W-1:0] rx_word_o,
  output logic               frame_ok_o,
  output logic               miso_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] rx_q;
  logic [FRAME_W-1:0] tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else if (csn_e_i.fall) begin
      cnt_q <= '0;
      tx_q  <= rb_word_i;
    end else if (!csn_e_i.level) begin
      if (sclk_e_i.rise) begin
        rx_q <= {rx_q[FRAME_W-2:0], mosi_i};
        // saturate one past full so long frames never alias to valid
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
      if (sclk_e_i.fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign rx_word_o  = rx_q;
  assign frame_ok_o = (cnt_q == CNT_FULL);
  assign miso_o     = tx_q[FRAME_W-1] & ~csn_e_i.level;
endmodule

// File: rtl/col_mem_bank.sv
module col_mem_bank #(
  parameter int unsigned CMD_W   = 8,
  parameter int unsigned COL_W   = 64,
  parameter int unsigned GROUPS  = 2,
  localparam int unsigned FRAME_W = CMD_W + COL_W,
  localparam int unsigned GRP_W   = COL_W / GROUPS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  colmem_pkg::edge_t  csn_e_i,
  input  logic               frame_ok_i,
  input  logic [FRAME_W-1:0] rx_word_i,
  output logic [COL_W-1:0]   col_on_o,
  output logic [CMD_W-1:0]   cmd_o,
  output logic [FRAME_W-1:0] rb_word_o
);
  logic             blank_q;
  logic             commit;
  logic [CMD_W-1:0] cmd_q;

  assign commit = csn_e_i.rise & frame_ok_i;

  // blank and memory change on the same edge: no stale-data cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              blank_q <= 1'b0;
    else if (csn_e_i.fall)    blank_q <= 1'b1;
    else if (csn_e_i.rise)    blank_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '0;
    else if (commit) cmd_q <= rx_word_i[FRAME_W-1 -: CMD_W];
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [GRP_W-1:0] mem_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mem_q <= '0;
      else if (commit) mem_q <= rx_word_i[g*GRP_W +: GRP_W];
    end
    assign col_on_o[g*GRP_W +: GRP_W]  = blank_q ? '0 : mem_q;
    assign rb_word_o[g*GRP_W +: GRP_W] = mem_q;
  end

  assign rb_word_o[FRAME_W-1 -: CMD_W] = cmd_q;
  assign cmd_o = cmd_q;
endmodule

// File: rtl/colmem_spi_top.sv
module colmem_spi_top #(
  parameter int unsigned COL_W       = colmem_pkg::COL_W_DEF,
  parameter int unsigned CMD_W       = colmem_pkg::CMD_W_DEF,
  parameter int unsigned COL_GROUPS  = colmem_pkg::GROUPS_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             spi_sclk_i,
  input  logic             spi_csn_i,
  input  logic             spi_mosi_i,
  output logic             spi_miso_o,
  output logic [COL_W-1:0] col_on_o,
  output logic [CMD_W-1:0] cmd_o
);
  localparam int unsigned FRAME_W = CMD_W + COL_W;

  colmem_pkg::edge_t  sclk_e, csn_e, mosi_e;
  logic [FRAME_W-1:0] rx_word;
  logic [FRAME_W-1:0] rb_word;
  logic               frame_ok;

  spi_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(spi_sclk_i), .e_o(sclk_e));
  spi_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(spi_csn_i), .e_o(csn_e));
  spi_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(spi_mosi_i), .e_o(mosi_e));

  spi_frame_rx #(.CMD_W(CMD_W), .COL_W(COL_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_e_i(sclk_e), .csn_e_i(csn_e),
    .mosi_i(mosi_e.level), .rb_word_i(rb_word), .rx_word_o(rx_word),
    .frame_ok_o(frame_ok), .miso_o(spi_miso_o));

  col_mem_bank #(.CMD_W(CMD_W), .COL_W(COL_W), .GROUPS(COL_GROUPS)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .csn_e_i(csn_e), .frame_ok_i(frame_ok),
    .rx_word_i(rx_word), .col_on_o(col_on_o), .cmd_o(cmd_o), .rb_word_o(rb_word));
endmodule

// File: rtl/colmem_spi_chk.sv
module colmem_spi_chk #(
  parameter int unsigned COL_W = 64,
  parameter int unsigned CMD_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csn_lvl,
  input logic             csn_rise,
  input logic             csn_fall,
  input logic             frame_ok,
  input logic [COL_W-1:0] rx_col,
  input logic [COL_W-1:0] col_on_o,
  input logic [CMD_W-1:0] cmd_o,
  input logic             spi_miso_o
);
  p_blank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_fall |=> col_on_o == '0);

  p_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_rise && frame_ok) |=> col_on_o == $past(rx_col));

  p_discard_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_rise && !frame_ok) |=> $stable(cmd_o));

  p_miso_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_lvl && !csn_rise) |-> !spi_miso_o);

  p_cmd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csn_rise |=> $stable(cmd_o));
endmodule

bind colmem_spi_top colmem_spi_chk #(.COL_W(COL_W), .CMD_W(CMD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .csn_lvl(csn_e.level), .csn_rise(csn_e.rise),
  .csn_fall(csn_e.fall), .frame_ok(frame_ok), .rx_col(rx_word[COL_W-1:0]),
  .col_on_o(col_on_o), .cmd_o(cmd_o), .spi_miso_o(spi_miso_o));

// File: tb/sim_colmem_spi_top.sv
`timescale 1ns/1ps
module sim_colmem_spi_top;
  localparam int FW   = 72;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic        miso;
  logic [63:0] col;
  logic [7:0]  cmd;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0]  exp_cmd = '0;
  logic [63:0] exp_col = '0;

  always #2 clk = ~clk;

  colmem_spi_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .spi_sclk_i(sclk), .spi_csn_i(csn),
    .spi_mosi_i(mosi), .spi_miso_o(miso), .col_on_o(col), .cmd_o(cmd));

  // {bit count, command, column word}
  localparam logic [79:0] VEC [0:5] = '{
    {8'd72, 8'hA5, 64'h0123_4567_89AB_CDEF},
    {8'd72, 8'h3C, 64'hFFFF_FFFF_0000_0000},
    {8'd71, 8'hFF, 64'hDEAD_BEEF_CAFE_F00D},
    {8'd72, 8'h01, 64'h8000_0000_0000_0001},
    {8'd73, 8'h77, 64'h5555_5555_5555_5555},
    {8'd72, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF}
  };

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [71:0] w, input int n);
    logic [71:0] prev;
    prev = {exp_cmd, exp_col};
    @(negedge clk) csn = 1'b0;
    repeat (HALF) @(negedge clk);
    chk("R3 blank", {8'h0, col}, 72'h0);
    for (int i = 0; i < n; i++) begin
      mosi = (i < FW) ? w[FW-1-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < FW) chk("R6 readback", {71'h0, miso}, {71'h0, prev[FW-1-i]});
      if (i == 4) begin
        chk("R3 blank mid", {8'h0, col}, 72'h0);
        chk("R7 cmd hold", {64'h0, cmd}, {64'h0, exp_cmd});
      end
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    chk("R3 blank end", {8'h0, col}, 72'h0);
    csn = 1'b1;
    repeat (HALF) @(negedge clk);
    if (n == FW) begin
      exp_cmd = w[71:64];
      exp_col = w[63:0];
    end
  endtask

  task automatic check_state(input string req);
    chk(req, {cmd, col}, {exp_cmd, exp_col});
    chk("R6 idle", {71'h0, miso}, 72'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset held", {cmd, col}, 72'h0);
    chk("R1 miso", {71'h0, miso}, 72'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1 after release");

    for (int v = 0; v < 6; v++) begin
      send_frame(VEC[v][71:0], int'(VEC[v][79:72]));
      check_state(VEC[v][79:72] == 8'd72 ? "R4 commit" : "R5 discard");
    end

    // R2: bit order, first column bit lands at index 63, group boundary at 32
    send_frame({8'h80, 64'h8000_0001_0000_0000}, FW);
    chk("R2 order", {cmd, col}, {8'h80, 64'h8000_0001_0000_0000});

    // R5: zero-clock frame
    send_frame(72'hFF_FFFF_FFFF_FFFF_FFFF, 0);
    check_state("R5 empty frame");

    // R5: one bit short right after a good frame
    send_frame({8'h5A, 64'h0F0F_0F0F_0F0F_0F0F}, FW);
    check_state("R4 commit");
    send_frame({8'hC3, 64'h1234_0000_0000_4321}, FW - 1);
    check_state("R5 short");

    // R1: reset after data loaded
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset again", {cmd, col}, 72'h0);
    rst_n = 1'b1;
    exp_cmd = '0;
    exp_col = '0;
    repeat (4) @(negedge clk);
    check_state("R1 after second reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL timeout all requirements act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule